// File: doc/BRIEF.md
# I2C Register-Access Slave with Control-Byte Addressing

This block is an I2C slave that turns plain byte transfers into memory accesses. A transaction starts with the slave address. Once that address is matched and acknowledged, the master sends a control byte. This byte picks an access address that is one, two or four bytes wide, and it says whether the master intends to write or to read. The slave then gathers the address bytes, most significant first. On a master write, each data byte that follows goes out on a write port to a local register array, and the address steps by one after each byte.

A read works in two parts. The master first sets the address with a control byte that has its direction bit set. It then issues a repeated START with the read bit set in the slave address. The slave returns bytes taken from a combinational read port, and the pointer advances after every byte the master acknowledges. Both lines are synchronized into the system clock. The slave only ever pulls SDA low, and it changes SDA only while SCL is low. A busy output covers the span from the address match to STOP. A completion flag, which software clears, marks the STOP that closes a transaction the slave took part in, and it can raise an interrupt.

Top module: `i2c_cba_slave`

## Requirements
- R1: The first byte after any START carries the slave address in bits [7:1] and the read bit in bit 0. A match is acknowledged. A mismatch is not acknowledged, and every later byte is left unacknowledged and unwritten until the next START.
- R2: The byte after a matched write-address is the control byte and is acknowledged. Its bits [2:1] give the address width (00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes). Bit 0 = 0 selects a write and bit 0 = 1 selects address setup for a read. Bits [7:3] have no effect.
- R3: A control byte with bits [2:1] = 11 is not acknowledged. All further bytes are left unacknowledged and unwritten until START or STOP.
- R4: The address bytes follow the control byte, most significant first. Each one is acknowledged.
- R5: In write mode, each data byte after the address phase is acknowledged and produces a one-cycle wr_en_o pulse with wr_addr_o and wr_data_o. The address then rises by one, modulo 2^(8 × width in bytes).
- R6: When control bit 0 = 1, data bytes after the address phase are not acknowledged and are not written.
- R7: A slave address with bit 0 = 1 is acknowledged. The slave then sends rd_data_i for rd_addr_o, MSB first. After each master ACK the pointer advances with the same wrap as R5. After a master NACK the slave stops driving. The pointer is kept across a repeated START.
- R8: A repeated START at any point restarts parsing at the slave-address byte. Bytes already written stay written.
- R9: busy_o is low after reset, goes high on an address match, and falls only on a STOP.
- R10: done_o is set by a STOP while busy_o is high and stays set until a done_clr_i pulse clears it. If both happen in the same cycle, the set wins. irq_o equals done_o AND irq_en_i.
- R11: sda_oe_o (1 = pull SDA low) changes only while the synchronized SCL is low.
- R12: After reset, sda_oe_o, busy_o, done_o, irq_o and wr_en_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| own_addr_i | input | 7 | Slave address to match |
| wr_en_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 8*PTR_BYTES | Write address |
| wr_data_o | output | 8 | Write data |
| rd_addr_o | output | 8*PTR_BYTES | Current access pointer for reads |
| rd_data_i | input | 8 | Read data for rd_addr_o, combinational |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Completion flag |
| done_clr_i | input | 1 | Clear pulse for done_o |
| irq_en_i | input | 1 | Interrupt enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle the properties that hold locally. SDA drive moves only while SCL is low. The slave never drives SDA while it is ignoring the bus. Each write strobe lasts one cycle. busy falls only on a STOP. The completion flag sets on the closing STOP and clears only on a software pulse. An 8-bit pointer never grows past its width. Some behaviour only the bench scenarios can show: that the width field selects how many bytes are parsed, the byte order, the wrap at each width, the refusal of reserved widths and of write data in read-setup mode, read data ordering, pointer persistence across a repeated START, and commitment of earlier bytes at a restart.

// File: rtl/i2c_cba_pkg.sv
// Shared types for the control-byte addressed I2C slave.
// Assumes: widths of at most four address bytes.
package i2c_cba_pkg;
    typedef enum logic [2:0] {PH_IDLE, PH_RX, PH_ACK, PH_TX, PH_MACK} phase_t;
    typedef enum logic [1:0] {RL_SADDR, RL_CTRL, RL_ADDR, RL_DATA} role_t;

    localparam logic [1:0] SZ_RESERVED = 2'b11;

    // Number of address bytes selected by the control byte width field.
    function automatic logic [2:0] width_bytes(input logic [1:0] sz);
        case (sz)
            2'b00:   return 3'd1;
            2'b01:   return 3'd2;
            2'b10:   return 3'd4;
            default: return 3'd0;
        endcase
    endfunction
endpackage

// File: rtl/i2c_cba_lines.sv
// Line conditioner: synchronizes SCL and SDA and derives edge and bus events.
// Assumes: the system clock is much faster than SCL; idle lines are high.
module i2c_cba_lines #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic scl_d, sda_d;

    // Synchronizer chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_cba_ptr.sv
// Access pointer: loads address bytes MSB first, increments with wrap at the
// width chosen by the control byte. Assumes PTR_BYTES >= 2.
module i2c_cba_ptr #(
    parameter int PTR_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   size_set,
    input  logic [1:0]             size_in,
    input  logic                   load,
    input  logic [7:0]             load_byte,
    input  logic                   inc,
    output logic [8*PTR_BYTES-1:0] ptr
);
    import i2c_cba_pkg::*;
    localparam int PW = 8 * PTR_BYTES;

    logic [2:0]    nbytes;
    logic [PW-1:0] wrap_mask;

    // Mask of the byte lanes covered by the selected width.
    always_comb begin
        wrap_mask = '0;
        for (int i = 0; i < PTR_BYTES; i++) begin
            if (i < int'(nbytes)) wrap_mask[8*i +: 8] = 8'hFF;
        end
    end

    // Width register and pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nbytes <= 3'd1;
            ptr    <= '0;
        end else begin
            if (size_set) nbytes <= width_bytes(size_in);
            if (clr)       ptr <= '0;
            else if (load) ptr <= {ptr[PW-9:0], load_byte};
            else if (inc)  ptr <= (ptr + 1'b1) & wrap_mask;
        end
    end

    // R5: an 8-bit pointer stays within its width after stepping.
    a_r5_wrap_8bit: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !load && !size_set && nbytes == 3'd1) |=> (ptr[PW-1:8] == '0));
endmodule

// File: rtl/i2c_cba_fsm.sv
// Protocol engine: bit and byte sequencing, ACK/NACK, control-byte parsing,
// address phase, write strobes and read transmission.
// Assumes: events come from i2c_cba_lines; the read port is combinational.
module i2c_cba_fsm #(
    parameter int PTR_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_s,
    input  logic                   sda_s,
    input  logic                   scl_rise,
    input  logic                   scl_fall,
    input  logic                   start_evt,
    input  logic                   stop_evt,
    input  logic [6:0]             own_addr,
    input  logic [7:0]             rd_data,
    input  logic [8*PTR_BYTES-1:0] ptr,
    output logic                   sda_oe,
    output logic                   busy,
    output logic                   txn_end,
    output logic                   wr_en,
    output logic [7:0]             wr_data,
    output logic [8*PTR_BYTES-1:0] wr_addr,
    output logic                   ptr_clr,
    output logic                   size_set,
    output logic [1:0]             size_val,
    output logic                   ptr_load,
    output logic [7:0]             ptr_byte,
    output logic                   ptr_inc
);
    import i2c_cba_pkg::*;

    phase_t     phase;
    role_t      role;
    logic [3:0] bitcnt;
    logic [7:0] rx_sh, tx_sh;
    logic       go_tx, dir_rd, mack_ok;
    logic [2:0] addr_left;
    logic       byte_end, ctrl_ok;

    // Byte completion point: the falling SCL edge after the eighth bit.
    assign byte_end = (phase == PH_RX) && scl_fall && (bitcnt == 4'd8);
    assign ctrl_ok  = (rx_sh[2:1] != SZ_RESERVED);
    assign ptr_clr  = byte_end && role == RL_CTRL && ctrl_ok;
    assign size_set = ptr_clr;
    assign size_val = rx_sh[2:1];
    assign ptr_load = byte_end && role == RL_ADDR;
    assign ptr_byte = rx_sh;
    assign ptr_inc  = (byte_end && role == RL_DATA && !dir_rd)
                    || (phase == PH_MACK && scl_rise && !sda_s);
    assign txn_end  = stop_evt && busy;

    // Main sequencer: phase, shift registers, SDA drive and write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            role      <= RL_SADDR;
            bitcnt    <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            go_tx     <= 1'b0;
            dir_rd    <= 1'b0;
            mack_ok   <= 1'b0;
            addr_left <= '0;
            sda_oe    <= 1'b0;
            busy      <= 1'b0;
            wr_en     <= 1'b0;
            wr_data   <= '0;
            wr_addr   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_evt) begin
                phase  <= PH_RX;
                role   <= RL_SADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_evt) begin
                phase  <= PH_IDLE;
                sda_oe <= 1'b0;
                busy   <= 1'b0;
            end else begin
                case (phase)
                    PH_RX: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            rx_sh  <= {rx_sh[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (byte_end) begin
                            bitcnt <= '0;
                            case (role)
                                RL_SADDR: begin
                                    if (rx_sh[7:1] == own_addr) begin
                                        busy   <= 1'b1;
                                        sda_oe <= 1'b1;
                                        phase  <= PH_ACK;
                                        go_tx  <= rx_sh[0];
                                        role   <= RL_CTRL;
                                    end else begin
                                        phase <= PH_IDLE;
                                    end
                                end
                                RL_CTRL: begin
                                    if (ctrl_ok) begin
                                        sda_oe    <= 1'b1;
                                        phase     <= PH_ACK;
                                        go_tx     <= 1'b0;
                                        dir_rd    <= rx_sh[0];
                                        addr_left <= width_bytes(rx_sh[2:1]);
                                        role      <= RL_ADDR;
                                    end else begin
                                        phase <= PH_IDLE;
                                    end
                                end
                                RL_ADDR: begin
                                    sda_oe    <= 1'b1;
                                    phase     <= PH_ACK;
                                    go_tx     <= 1'b0;
                                    addr_left <= addr_left - 3'd1;
                                    if (addr_left == 3'd1) role <= RL_DATA;
                                end
                                default: begin
                                    if (!dir_rd) begin
                                        sda_oe  <= 1'b1;
                                        phase   <= PH_ACK;
                                        go_tx   <= 1'b0;
                                        wr_en   <= 1'b1;
                                        wr_data <= rx_sh;
                                        wr_addr <= ptr;
                                    end else begin
                                        phase <= PH_IDLE;
                                    end
                                end
                            endcase
                        end
                    end
                    PH_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (go_tx) begin
                                tx_sh  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                phase  <= PH_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                phase  <= PH_RX;
                            end
                        end
                    end
                    PH_TX: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                phase  <= PH_MACK;
                            end else begin
                                tx_sh  <= {tx_sh[6:0], 1'b0};
                                sda_oe <= ~tx_sh[6];
                            end
                        end
                    end
                    PH_MACK: begin
                        if (scl_rise) begin
                            mack_ok <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack_ok) begin
                                tx_sh  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                bitcnt <= '0;
                                phase  <= PH_TX;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11: SDA drive does not move while SCL stays high.
    a_r11_sda_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && !scl_rise) |-> $stable(sda_oe));
    // R1: the slave never drives SDA while it ignores the bus.
    a_r1_quiet_when_ignoring: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !sda_oe);
    // R9: busy ends only on a STOP.
    a_r9_busy_ends_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(stop_evt));
    // R5: every write strobe lasts a single cycle.
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
endmodule

// File: rtl/i2c_cba_slave.sv
// Top level: control-byte addressed I2C slave with completion flag and IRQ.
// Assumes: SCL is driven by the master only; the read port is combinational.
module i2c_cba_slave #(
    parameter int PTR_BYTES   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe_o,
    input  logic [6:0]             own_addr_i,
    output logic                   wr_en_o,
    output logic [8*PTR_BYTES-1:0] wr_addr_o,
    output logic [7:0]             wr_data_o,
    output logic [8*PTR_BYTES-1:0] rd_addr_o,
    input  logic [7:0]             rd_data_i,
    output logic                   busy_o,
    output logic                   done_o,
    input  logic                   done_clr_i,
    input  logic                   irq_en_i,
    output logic                   irq_o
);
    localparam int PW = 8 * PTR_BYTES;

    logic          scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic          txn_end, ptr_clr, size_set, ptr_load, ptr_inc;
    logic [1:0]    size_val;
    logic [7:0]    ptr_byte;
    logic [PW-1:0] ptr;
    logic          done_q;

    i2c_cba_lines #(.STAGES(SYNC_STAGES)) lines_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    i2c_cba_fsm #(.PTR_BYTES(PTR_BYTES)) fsm_i (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .own_addr(own_addr_i), .rd_data(rd_data_i), .ptr(ptr),
        .sda_oe(sda_oe_o), .busy(busy_o), .txn_end(txn_end),
        .wr_en(wr_en_o), .wr_data(wr_data_o), .wr_addr(wr_addr_o),
        .ptr_clr(ptr_clr), .size_set(size_set), .size_val(size_val),
        .ptr_load(ptr_load), .ptr_byte(ptr_byte), .ptr_inc(ptr_inc)
    );

    i2c_cba_ptr #(.PTR_BYTES(PTR_BYTES)) ptr_i (
        .clk(clk), .rst_n(rst_n), .clr(ptr_clr), .size_set(size_set),
        .size_in(size_val), .load(ptr_load), .load_byte(ptr_byte),
        .inc(ptr_inc), .ptr(ptr)
    );

    // Completion flag: set by a closing STOP, cleared by software; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)          done_q <= 1'b0;
        else if (txn_end)    done_q <= 1'b1;
        else if (done_clr_i) done_q <= 1'b0;
    end

    assign rd_addr_o = ptr;
    assign done_o    = done_q;
    assign irq_o     = done_q & irq_en_i;

    // R10: a closing STOP always leaves the flag set.
    a_r10_done_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        txn_end |=> done_o);
    // R10: the flag drops only after a clear pulse.
    a_r10_clear_by_sw: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_o) |-> $past(done_clr_i));
endmodule

// File: tb/i2c_cba_slave_tb.sv
module i2c_cba_slave_tb_top;
    localparam logic [6:0] OWN = 7'h2C;
    localparam int Q = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic        sda_oe, wr_en, busy, done, irq;
    logic        done_clr = 1'b0, irq_en = 1'b0;
    logic [31:0] wr_addr, rd_addr;
    logic [7:0]  wr_data, rd_data;
    logic        sda_line;

    int total = 0, failed = 0, nlog = 0, r11_viol = 0;
    logic [31:0] log_a [16];
    logic [7:0]  log_d [16];
    logic        prev_scl = 1'b1, prev_oe = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    function automatic logic [7:0] model_rd(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'hA5;
    endfunction
    assign rd_data = model_rd(rd_addr);

    function automatic logic [31:0] wrapped(input logic [31:0] b, input int i, input int sz);
        logic [31:0] m;
        m = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
        return (b + 32'(i)) & m;
    endfunction

    i2c_cba_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .own_addr_i(OWN), .wr_en_o(wr_en),
        .wr_addr_o(wr_addr), .wr_data_o(wr_data), .rd_addr_o(rd_addr),
        .rd_data_i(rd_data), .busy_o(busy), .done_o(done),
        .done_clr_i(done_clr), .irq_en_i(irq_en), .irq_o(irq)
    );

    // Write-port log and R11 monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && wr_en && nlog < 16) begin
            log_a[nlog] = wr_addr;
            log_d[nlog] = wr_data;
            nlog++;
        end
        if (rst_n && scl_m && prev_scl && sda_oe != prev_oe) r11_viol++;
        prev_scl = scl_m;
        prev_oe  = sda_oe;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic m_wbit(input logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic m_rbit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic m_wbyte(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) m_wbit(d[i]);
        m_rbit(b);
        acked = ~b;
    endtask

    task automatic m_rbyte(input logic give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            m_rbit(b);
            d[i] = b;
        end
        m_wbit(~give_ack);
    endtask

    task automatic clear_done();
        done_clr = 1'b1; tick(1);
        done_clr = 1'b0; tick(1);
    endtask

    initial begin
        logic ak;
        logic [7:0] rd;
        tick(5);
        // R12: reset state
        chk(sda_oe == 1'b0, "R12 sda_oe", 32'(sda_oe), 0);
        chk(busy == 1'b0, "R12 busy", 32'(busy), 0);
        chk(done == 1'b0, "R12 done", 32'(done), 0);
        chk(wr_en == 1'b0 && irq == 1'b0, "R12 wr_en/irq", 32'({wr_en, irq}), 0);
        rst_n = 1'b1;
        tick(4);

        // R2 R4 R5: write sweep over widths, with and without reserved upper bits
        for (int sz = 0; sz < 3; sz++) begin
            for (int v = 0; v < 2; v++) begin
                logic [31:0] base;
                logic [7:0]  cb;
                int nb;
                nb   = 1 << sz;
                base = (v == 0) ? wrapped(32'h1234_5610 + 32'(sz), 0, sz) : wrapped(32'hFFFF_FFFE, 0, sz);
                cb   = {(v == 1) ? 5'b10101 : 5'b00000, 2'(sz), 1'b0};
                nlog = 0;
                m_start();
                m_wbyte({OWN, 1'b0}, ak);
                chk(ak, "R1 address ack", 32'(ak), 1);
                chk(busy, "R9 busy after match", 32'(busy), 1);
                m_wbyte(cb, ak);
                chk(ak, "R2 control ack", 32'(ak), 1);
                for (int k = nb - 1; k >= 0; k--) begin
                    m_wbyte(8'(base >> (8 * k)), ak);
                    chk(ak, "R4 address byte ack", 32'(ak), 1);
                end
                for (int i = 0; i < 3; i++) begin
                    m_wbyte(8'(8'h30 + 16 * sz + 4 * v + i), ak);
                    chk(ak, "R5 data ack", 32'(ak), 1);
                end
                m_stop();
                tick(2);
                chk(nlog == 3, "R5 write count", 32'(nlog), 3);
                for (int i = 0; i < 3 && i < nlog; i++) begin
                    chk(log_a[i] == wrapped(base, i, sz), "R5 write address", log_a[i], wrapped(base, i, sz));
                    chk(log_d[i] == 8'(8'h30 + 16 * sz + 4 * v + i), "R5 write data", 32'(log_d[i]),
                        32'(8'h30 + 16 * sz + 4 * v + i));
                end
                chk(busy == 1'b0, "R9 busy after stop", 32'(busy), 0);
                chk(done == 1'b1, "R10 done after stop", 32'(done), 1);
                clear_done();
                chk(done == 1'b0, "R10 done cleared", 32'(done), 0);
            end
        end

        // R6 R7: read setup at the top of each width, write data refused, then read with wrap
        for (int sz = 0; sz < 3; sz++) begin
            logic [31:0] base;
            int nb;
            nb   = 1 << sz;
            base = wrapped(32'hFFFF_FFFF, 0, sz);
            nlog = 0;
            m_start();
            m_wbyte({OWN, 1'b0}, ak);
            m_wbyte({5'b0, 2'(sz), 1'b1}, ak);
            chk(ak, "R2 read-setup control ack", 32'(ak), 1);
            for (int k = nb - 1; k >= 0; k--) m_wbyte(8'(base >> (8 * k)), ak);
            m_wbyte(8'h77, ak);
            chk(!ak, "R6 data nack in read setup", 32'(ak), 0);
            m_start();
            m_wbyte({OWN, 1'b1}, ak);
            chk(ak, "R7 read address ack", 32'(ak), 1);
            for (int i = 0; i < 3; i++) begin
                m_rbyte(i < 2, rd);
                chk(rd == model_rd(wrapped(base, i, sz)), "R7 read data", 32'(rd), 32'(model_rd(wrapped(base, i, sz))));
            end
            chk(sda_oe == 1'b0, "R7 released after nack", 32'(sda_oe), 0);
            m_stop();
            tick(2);
            chk(nlog == 0, "R6 no write", 32'(nlog), 0);
            clear_done();
        end

        // R3: reserved width field
        nlog = 0;
        m_start();
        m_wbyte({OWN, 1'b0}, ak);
        m_wbyte(8'h06, ak);
        chk(!ak, "R3 reserved control nack", 32'(ak), 0);
        m_wbyte(8'h00, ak);
        chk(!ak, "R3 later byte nack", 32'(ak), 0);
        m_wbyte(8'h55, ak);
        m_stop();
        tick(2);
        chk(nlog == 0, "R3 no write", 32'(nlog), 0);
        clear_done();

        // R1 R10: address mismatch
        m_start();
        m_wbyte({OWN ^ 7'h01, 1'b0}, ak);
        chk(!ak, "R1 mismatch nack", 32'(ak), 0);
        chk(busy == 1'b0, "R9 no busy on mismatch", 32'(busy), 0);
        m_wbyte(8'h00, ak);
        chk(!ak, "R1 ignored after mismatch", 32'(ak), 0);
        m_stop();
        tick(2);
        chk(done == 1'b0, "R10 no done on mismatch", 32'(done), 0);

        // R8: repeated START mid-write commits earlier bytes and restarts parsing
        nlog = 0;
        m_start();
        m_wbyte({OWN, 1'b0}, ak);
        m_wbyte(8'h00, ak);
        m_wbyte(8'h10, ak);
        m_wbyte(8'h11, ak);
        m_wbyte(8'h22, ak);
        m_start();
        m_wbyte({OWN, 1'b0}, ak);
        chk(ak, "R8 address after restart ack", 32'(ak), 1);
        m_wbyte(8'h00, ak);
        m_wbyte(8'h40, ak);
        m_wbyte(8'h33, ak);
        m_stop();
        tick(2);
        chk(nlog == 3, "R8 write count", 32'(nlog), 3);
        chk(log_a[0] == 32'h10 && log_d[0] == 8'h11, "R8 first byte", {log_a[0][23:0], log_d[0]}, 32'h0000_1011);
        chk(log_a[1] == 32'h11 && log_d[1] == 8'h22, "R8 second byte", {log_a[1][23:0], log_d[1]}, 32'h0000_1122);
        chk(log_a[2] == 32'h40 && log_d[2] == 8'h33, "R8 after restart", {log_a[2][23:0], log_d[2]}, 32'h0000_4033);

        // R10: interrupt gating
        chk(done && !irq, "R10 irq masked", 32'(irq), 0);
        irq_en = 1'b1; tick(1);
        chk(irq == 1'b1, "R10 irq enabled", 32'(irq), 1);
        clear_done();
        chk(irq == 1'b0, "R10 irq after clear", 32'(irq), 0);

        chk(r11_viol == 0, "R11 drive change while SCL high", 32'(r11_viol), 0);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (190000) @(negedge clk);
        total++;
        failed++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule